// File: doc/BRIEF.md
# Chained Bus Grant Arbiter

This block decides which of several DMA-capable masters may take the shared system bus away from the processor. Every master that wants the bus raises a private request, and these requests are merged into one bus-request line. When the processor side sees that line active while the bus-busy line is low, it raises a single grant at the head of a chain of per-master cells. The grant moves down the chain one cell per clock. A cell whose master is waiting keeps the grant. A cell whose master is not waiting passes it to the next cell. The cell that keeps the grant takes bus-busy and withdraws its request in the same clock. The processor then lowers its grant. When the master signals that it has finished, bus-busy falls and the bus returns to the processor. A new round begins only after every grant in the chain has drained to zero.

Priority comes from position in the chain: cell 0 sits nearest the processor and beats every cell behind it. A cell may keep the grant only on the clock in which its incoming grant rises. A request that appears while a grant is already passing through a cell therefore cannot capture that grant, and cannot take the bus from a master further down the chain.

The processor-side controller has four states. SRC_OWN means the processor holds the bus with no grant out. SRC_GRANT means the head grant is raised. SRC_LENT means a master holds the bus. SRC_SETTLE means the controller waits for the chain to drain. Its transitions are: issue (SRC_OWN to SRC_GRANT, when a request is present and the bus is not busy), lend (SRC_GRANT to SRC_LENT, when busy is seen), withdraw (SRC_GRANT to SRC_SETTLE, when the request line falls with no taker), reclaim (SRC_LENT to SRC_SETTLE, when busy falls) and rearm (SRC_SETTLE to SRC_OWN, when the chain is quiet). Each cell has three states. CELL_IDLE means no request. CELL_PEND means the cell is requesting. CELL_MASTER means the cell holds the bus. Its transitions are: ask (CELL_IDLE to CELL_PEND, when the request input is high), take (CELL_PEND to CELL_MASTER, on a rising grant while the request input is still high), cancel (CELL_PEND to CELL_IDLE, when the request input drops) and release (CELL_MASTER to CELL_IDLE, when the done input is high).

Top module: `bus_grant_chain`

## Requirements
- R1: `bus_req_o` is high exactly while at least one cell is in CELL_PEND. A cell enters CELL_PEND one clock after its `req_i` bit is sampled high, and it stops contributing one clock after it takes the bus or its `req_i` bit is sampled low.
- R2: Bit k+1 of `chain_grant_o` equals bit k one clock earlier, unless cell k is in CELL_MASTER or takes the grant on that edge. In those cases bit k+1 is low. Bit 0 equals `cpu_grant_o`.
- R3: `cpu_grant_o` rises only one clock after the controller, in SRC_OWN, has sampled `bus_req_o` high and `bus_busy_o` low.
- R4: A cell in CELL_PEND whose incoming grant bit is high, whose grant bit was low one clock earlier, and whose `req_i` bit is high becomes owner on the next clock. At most one bit of `owner_o` is ever high.
- R5: `bus_busy_o` is high exactly while some bit of `owner_o` is high. `cpu_grant_o` falls on the clock after it is sampled high together with `bus_busy_o`.
- R6: When several masters request before the grant reaches them, the one with the lowest index wins.
- R7: A cell whose request arrives while its incoming grant is already high does not take that grant, and the bus goes to a requesting cell further down the chain.
- R8: After `bus_busy_o` falls, `cpu_grant_o` stays low until every bit of `chain_grant_o` except bit 0 is low and the last cell's outgoing grant is low.
- R9: While `rst_n` is low, all outputs are low, and all outputs stay low after reset until a request is sampled.
- R10: If the request line falls while the head grant is up and no cell has taken it, `cpu_grant_o` falls one clock later and no owner appears.
- R11: A high `done_i` bit sampled while its cell is owner clears that bit of `owner_o` on the next clock. A `done_i` bit for a cell that is not owner has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Per-master request to use the bus |
| done_i | input | NUM_MASTERS | Per-master pulse: finished, release the bus |
| bus_req_o | output | 1 | Merged request line (OR of pending cells) |
| bus_busy_o | output | 1 | Merged bus-busy line (OR of owning cells) |
| cpu_grant_o | output | 1 | Head grant raised by the processor side |
| chain_grant_o | output | NUM_MASTERS | Incoming grant seen at each cell |
| owner_o | output | NUM_MASTERS | One-hot owner of the bus, zero when the processor owns it |

## Verification
A wrong controller state shows up on `cpu_grant_o` within one clock. A grant raised while busy, held after busy, or re-raised before the chain drains is visible on the first clock that the bench's reference model disagrees. A wrong cell state shows up on `bus_req_o`, on `owner_o`, or on the next bit of `chain_grant_o` one clock later. A missed or wrongly placed capture is caught as soon as the wave passes the cell. Because the bench compares every output on every clock against an independent cycle model, no divergence can hide for more than one clock. Directed runs add checks on priority order, on the no-capture rule for late requests, on withdrawal, and on the drain wait.

// File: rtl/bga_pkg.sv
package bga_pkg;

    // Processor-side arbitration controller
    typedef enum logic [1:0] {
        SRC_OWN    = 2'd0,
        SRC_GRANT  = 2'd1,
        SRC_LENT   = 2'd2,
        SRC_SETTLE = 2'd3
    } src_state_e;

    // Per-master chain cell
    typedef enum logic [1:0] {
        CELL_IDLE   = 2'd0,
        CELL_PEND   = 2'd1,
        CELL_MASTER = 2'd2
    } cell_state_e;

endpackage

// File: rtl/bga_line_merge.sv
// Logical model of an open-drain shared line: active when any driver pulls.
module bga_line_merge #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] lines_i,
    output logic             any_o
);

    logic [WIDTH:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_acc
        assign acc[i+1] = acc[i] | lines_i[i];
    end

    assign any_o = acc[WIDTH];

endmodule

// File: rtl/bga_grant_source.sv
// Processor side: raises the head grant and tracks bus ownership.
module bga_grant_source
    import bga_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_i,
    input  logic bus_busy_i,
    input  logic chain_quiet_i,
    output logic grant_o
);

    src_state_e state_q;
    src_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_OWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OWN: begin
                if (bus_req_i && !bus_busy_i) begin
                    state_d = SRC_GRANT;          // issue
                end
            end
            SRC_GRANT: begin
                if (bus_busy_i) begin
                    state_d = SRC_LENT;           // lend
                end else if (!bus_req_i) begin
                    state_d = SRC_SETTLE;         // withdraw
                end
            end
            SRC_LENT: begin
                if (!bus_busy_i) begin
                    state_d = SRC_SETTLE;         // reclaim
                end
            end
            SRC_SETTLE: begin
                if (chain_quiet_i) begin
                    state_d = SRC_OWN;            // rearm
                end
            end
            default: state_d = SRC_OWN;
        endcase
    end

    // Outputs
    always_comb begin
        grant_o = (state_q == SRC_GRANT);
    end

endmodule

// File: rtl/bga_chain_cell.sv
// One link of the grant chain: captures a rising grant when requesting,
// otherwise forwards it to the next link one clock later.
module bga_chain_cell
    import bga_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic done_i,
    input  logic grant_in_i,
    output logic grant_out_o,
    output logic req_o,
    output logic busy_o
);

    cell_state_e state_q;
    cell_state_e state_d;
    logic        grant_seen_q;
    logic        fwd_q;
    logic        fwd_d;
    logic        take;

    assign take = (state_q == CELL_PEND) && want_i && grant_in_i && !grant_seen_q;

    // State register and grant pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= CELL_IDLE;
            grant_seen_q <= 1'b0;
            fwd_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            grant_seen_q <= grant_in_i;
            fwd_q        <= fwd_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (want_i) begin
                    state_d = CELL_PEND;          // ask
                end
            end
            CELL_PEND: begin
                if (take) begin
                    state_d = CELL_MASTER;        // take
                end else if (!want_i) begin
                    state_d = CELL_IDLE;          // cancel
                end
            end
            CELL_MASTER: begin
                if (done_i) begin
                    state_d = CELL_IDLE;          // release
                end
            end
            default: state_d = CELL_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fwd_d       = grant_in_i && (state_q != CELL_MASTER) && !take;
        grant_out_o = fwd_q;
        req_o       = (state_q == CELL_PEND);
        busy_o      = (state_q == CELL_MASTER);
    end

endmodule

// File: rtl/bus_grant_chain.sv
module bus_grant_chain
    import bga_pkg::*;
#(
    parameter int unsigned NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] done_i,
    output logic                   bus_req_o,
    output logic                   bus_busy_o,
    output logic                   cpu_grant_o,
    output logic [NUM_MASTERS-1:0] chain_grant_o,
    output logic [NUM_MASTERS-1:0] owner_o
);

    localparam int unsigned LINKS = NUM_MASTERS + 1;

    logic [LINKS-1:0]       grant_link;
    logic [NUM_MASTERS-1:0] pend_lines;
    logic [NUM_MASTERS-1:0] busy_lines;
    logic                   any_req;
    logic                   any_busy;
    logic                   head_grant;
    logic                   chain_quiet;

    assign grant_link[0] = head_grant;
    assign chain_quiet   = ~|grant_link[LINKS-1:1];

    bga_grant_source u_source (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req_i     (any_req),
        .bus_busy_i    (any_busy),
        .chain_quiet_i (chain_quiet),
        .grant_o       (head_grant)
    );

    for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_cell
        bga_chain_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .want_i      (req_i[k]),
            .done_i      (done_i[k]),
            .grant_in_i  (grant_link[k]),
            .grant_out_o (grant_link[k+1]),
            .req_o       (pend_lines[k]),
            .busy_o      (busy_lines[k])
        );
    end

    bga_line_merge #(.WIDTH(NUM_MASTERS)) u_req_line (
        .lines_i (pend_lines),
        .any_o   (any_req)
    );

    bga_line_merge #(.WIDTH(NUM_MASTERS)) u_busy_line (
        .lines_i (busy_lines),
        .any_o   (any_busy)
    );

    assign bus_req_o     = any_req;
    assign bus_busy_o    = any_busy;
    assign cpu_grant_o   = head_grant;
    assign chain_grant_o = grant_link[NUM_MASTERS-1:0];
    assign owner_o       = busy_lines;

endmodule

// File: rtl/bga_chain_checker.sv
module bga_chain_checker #(
    parameter int unsigned NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req_i,
    input logic [NUM_MASTERS-1:0] done_i,
    input logic                   bus_req_o,
    input logic                   bus_busy_o,
    input logic                   cpu_grant_o,
    input logic [NUM_MASTERS-1:0] chain_grant_o,
    input logic [NUM_MASTERS-1:0] owner_o
);

    AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_grant_o) |-> $past(bus_req_o && !bus_busy_o)); // R3

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_o)); // R4

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_grant_o && bus_busy_o) |=> !cpu_grant_o); // R5

    AST_BUSY_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_o |-> ($countones(owner_o) == 1)); // R5

    AST_DRAINED_BEFORE_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_grant_o) |-> $past(~|(chain_grant_o >> 1))); // R8

    for (genvar k = 0; k < NUM_MASTERS; k++) begin : g_cell_chk
        AST_CAPTURE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(owner_o[k]) |-> $past(chain_grant_o[k] && req_i[k])); // R4

        AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_o[k] && done_i[k]) |=> !owner_o[k]); // R11

        if (k + 1 < NUM_MASTERS) begin : g_link
            AST_GRANT_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(chain_grant_o[k+1]) |-> $past(chain_grant_o[k])); // R2
        end
    end

endmodule

bind bus_grant_chain bga_chain_checker #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .done_i        (done_i),
    .bus_req_o     (bus_req_o),
    .bus_busy_o    (bus_busy_o),
    .cpu_grant_o   (cpu_grant_o),
    .chain_grant_o (chain_grant_o),
    .owner_o       (owner_o)
);

// File: tb/bus_grant_chain_tb_top.sv
`timescale 1ns/1ps
module bus_grant_chain_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] done = '0;
    logic         bus_req, bus_busy, cpu_grant;
    logic [N-1:0] chain_grant, owner;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bus_grant_chain #(.NUM_MASTERS(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .done_i        (done),
        .bus_req_o     (bus_req),
        .bus_busy_o    (bus_busy),
        .cpu_grant_o   (cpu_grant),
        .chain_grant_o (chain_grant),
        .owner_o       (owner)
    );

    // Behavioural reference: phase 0 own, 1 grant out, 2 lent, 3 draining.
    // Mode per master: 0 quiet, 1 waiting, 2 holding the bus.
    int ph = 0;
    int md [N];
    bit wave [N+1];
    bit last_in [N];

    initial begin
        for (int k = 0; k < N; k++) begin
            md[k] = 0;
            last_in[k] = 0;
        end
        for (int k = 0; k <= N; k++) wave[k] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            for (int k = 0; k < N; k++) begin
                md[k] = 0;
                last_in[k] = 0;
            end
            for (int k = 0; k <= N; k++) wave[k] = 0;
        end else begin
            bit waiting, holding, drained;
            bit incoming [N];
            int nmd [N];
            bit nwave [N+1];
            waiting = 0;
            holding = 0;
            drained = 1;
            for (int k = 0; k < N; k++) begin
                incoming[k] = (k == 0) ? (ph == 1) : wave[k];
                if (md[k] == 1) waiting = 1;
                if (md[k] == 2) holding = 1;
            end
            for (int k = 1; k <= N; k++) if (wave[k]) drained = 0;
            nwave[0] = 0;
            for (int k = 0; k < N; k++) begin
                bit grab;
                grab = (md[k] == 1) && req[k] && incoming[k] && !last_in[k];
                nmd[k] = md[k];
                case (md[k])
                    0: if (req[k]) nmd[k] = 1;
                    1: if (grab) nmd[k] = 2; else if (!req[k]) nmd[k] = 0;
                    default: if (done[k]) nmd[k] = 0;
                endcase
                nwave[k+1] = incoming[k] && (md[k] != 2) && !grab;
            end
            case (ph)
                0: if (waiting && !holding) ph = 1;
                1: if (holding) ph = 2; else if (!waiting) ph = 3;
                2: if (!holding) ph = 3;
                default: if (drained) ph = 0;
            endcase
            for (int k = 0; k < N; k++) begin
                last_in[k] = incoming[k];
                md[k] = nmd[k];
            end
            for (int k = 0; k <= N; k++) wave[k] = nwave[k];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] e_chain, e_owner;
        logic e_req, e_busy, e_cpu;
        e_req = 0;
        e_busy = 0;
        e_cpu = (ph == 1);
        for (int k = 0; k < N; k++) begin
            e_chain[k] = (k == 0) ? e_cpu : wave[k];
            e_owner[k] = (md[k] == 2);
            if (md[k] == 1) e_req = 1;
            if (md[k] == 2) e_busy = 1;
        end
        check(bus_req == e_req, "R1 request line", 32'(bus_req), 32'(e_req));
        check(chain_grant == e_chain, "R2 grant chain", 32'(chain_grant), 32'(e_chain));
        check(cpu_grant == e_cpu, "R3 head grant", 32'(cpu_grant), 32'(e_cpu));
        check(owner == e_owner, "R4 owner", 32'(owner), 32'(e_owner));
        check(bus_busy == e_busy, "R5 busy line", 32'(bus_busy), 32'(e_busy));
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic wait_owner(output logic [N-1:0] who);
        who = '0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (owner != 0) begin
                who = owner;
                break;
            end
        end
    endtask

    task automatic release_owner(input int k);
        req[k] = 1'b0;
        done[k] = 1'b1;
        step();
        done[k] = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL R4 watchdog act=%0d exp<%0d", cyc, 60000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] who;
        // R9: reset values
        #1;
        check({bus_req, bus_busy, cpu_grant, chain_grant, owner} == '0, "R9 in reset", 32'({bus_req, bus_busy, cpu_grant, chain_grant, owner}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step();
        check({bus_req, bus_busy, cpu_grant, chain_grant, owner} == '0, "R9 quiet after reset", 32'({bus_req, bus_busy, cpu_grant, chain_grant, owner}), 0);

        // Single requester: grant at head two clocks after request, captured at cell 2
        req[2] = 1'b1;
        step();
        check(bus_req == 1'b1, "R1 request seen", 32'(bus_req), 1);
        step();
        check(cpu_grant == 1'b1, "R3 head grant issued", 32'(cpu_grant), 1);
        wait_owner(who);
        check(who == 4'b0100, "R4 single requester wins", 32'(who), 32'h4);
        check(bus_req == 1'b0, "R1 request dropped by owner", 32'(bus_req), 0);
        step();
        check(cpu_grant == 1'b0, "R5 head grant dropped", 32'(cpu_grant), 0);
        // R11: done to a non-owner is ignored
        done[0] = 1'b1;
        step();
        done[0] = 1'b0;
        step();
        check(owner == 4'b0100, "R11 done of non-owner ignored", 32'(owner), 32'h4);
        release_owner(2);
        check(owner == 0 && bus_busy == 0, "R11 release on done", 32'(owner), 0);
        for (int i = 0; i < 8; i++) step();

        // R6: position priority
        req[1] = 1'b1;
        req[3] = 1'b1;
        wait_owner(who);
        check(who == 4'b0010, "R6 nearest requester wins", 32'(who), 32'h2);
        release_owner(1);
        wait_owner(who);
        check(who == 4'b1000, "R6 next requester served after", 32'(who), 32'h8);
        release_owner(3);
        for (int i = 0; i < 8; i++) step();

        // R7: late request at cell 1 must not capture a passing grant
        req[3] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (chain_grant[2]) break;
        end
        check(chain_grant[1] == 1'b1, "R7 grant passing cell 1", 32'(chain_grant), 32'h2);
        req[1] = 1'b1;
        wait_owner(who);
        check(who == 4'b1000, "R7 no capture mid-grant", 32'(who), 32'h8);
        release_owner(3);
        // R8: no new head grant while the chain is still draining
        step();
        check(cpu_grant == 1'b0, "R8 wait for drain", 32'(cpu_grant), 0);
        wait_owner(who);
        check(who == 4'b0010, "R8 next round after drain", 32'(who), 32'h2);
        release_owner(1);
        for (int i = 0; i < 8; i++) step();

        // R10: requester withdraws while grant is in flight
        req[2] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (cpu_grant) break;
        end
        req[2] = 1'b0;
        for (int i = 0; i < 10; i++) step();
        check(owner == 0 && cpu_grant == 0, "R10 withdrawn request", 32'({owner, cpu_grant}), 0);

        // Mixed traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            step();
            for (int k = 0; k < N; k++) begin
                done[k] = 1'b0;
                if (owner[k]) begin
                    req[k] = 1'b0;
                    if ($urandom_range(3) == 0) done[k] = 1'b1;
                end else if (!req[k]) begin
                    if ($urandom_range(7) == 0) req[k] = 1'b1;
                    if ($urandom_range(15) == 0) done[k] = 1'b1;
                end else if ($urandom_range(40) == 0) begin
                    req[k] = 1'b0;
                end
            end
        end
        req = '0;
        done = '1;
        step();
        done = '0;
        for (int i = 0; i < 10; i++) step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule